// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block sits between instruction decode and issue. It accepts one decoded instruction that names a destination and two source registers. Each of the three operands carries a flag that marks it as a vector or a scalar. The instruction also brings an element count and an optional per-element enable mask. The block unrolls the instruction into per-element micro-operations and offers them one at a time on a valid/ready issue port. A vector operand's register index steps by one per element. A scalar operand stays on its base register. The same encoding therefore covers all eight scalar/vector mixes.

While the loop runs, the block asserts a hold on the program counter. When the loop ends it pulses a completion strobe, and the program counter may then move on. A scalar destination ends the loop after its first issued element. An element whose enable bit is clear is skipped without issuing anything. An element whose register index would pass the top of the register file ends the loop with an error pulse; the index never wraps.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset, `uopValid`, `pcHold`, `instDone` and `idxError` are all low.
- R2: `pcHold` is high from the cycle after an accepted `instStart` until the loop ends. `instDone` is then high for exactly one cycle, and `pcHold` is already low in that cycle.
- R3: For element i, each operand whose vector flag is 1 is issued with index base+i. Each operand whose flag is 0 is issued with its base index.
- R4: When `rtIsVec` is 0, the loop ends right after the first accepted micro-operation.
- R5: Micro-operations are issued in strictly rising element order, with each element at most once.
- R6: When `predEnable` is 1, element i is skipped (no micro-operation) when bit i of `predMask` is 0. When `predEnable` is 0, every element is enabled whatever the mask holds.
- R7: With a vector destination and no masking, elements 0 to VL-1 are issued with destinations RT to RT+VL-1. A `vecLen` above 64 is treated as 64.
- R8: With a scalar destination, masked leading elements are skipped and the first enabled element is issued. If no element is enabled, the loop ends with no issue.
- R9: `vecLen` of 0 ends the loop with no micro-operation.
- R10: If any vector operand index for the next enabled element would exceed 127, that element is not issued. The loop then ends, with `idxError` high in the same cycle as `instDone`.
- R11: While `uopValid` is high and `uopReady` is low, the offered micro-operation stays unchanged. The loop advances only on a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instStart | input | 1 | Start pulse for a decoded instruction; taken only while idle |
| rtBase | input | 7 | Destination base register |
| raBase | input | 7 | First source base register |
| rbBase | input | 7 | Second source base register |
| rtIsVec | input | 1 | Destination is a vector when 1 |
| raIsVec | input | 1 | First source is a vector when 1 |
| rbIsVec | input | 1 | Second source is a vector when 1 |
| vecLen | input | 7 | Element count, 0 to 127; values above 64 act as 64 |
| predEnable | input | 1 | Use the mask when 1; all elements enabled when 0 |
| predMask | input | 64 | Per-element enable bits, bit i for element i |
| uopValid | output | 1 | A micro-operation is offered |
| uopReady | input | 1 | Issue stage accepts the micro-operation |
| uopElem | output | 6 | Element number of the offered micro-operation |
| uopRt | output | 7 | Destination register index |
| uopRa | output | 7 | First source register index |
| uopRb | output | 7 | Second source register index |
| pcHold | output | 1 | Program counter must not advance |
| instDone | output | 1 | One-cycle pulse when the loop ends |
| idxError | output | 1 | Pulse with `instDone` when the loop ended on an index overflow |

## Verification
The assertions assume that `instStart` is raised only while `pcHold` and `instDone` are both low. They also assume that the instruction fields are stable in the cycle of the start pulse. The bench's driver starts a new instruction only after it has seen the completion pulse and one further cycle has passed, and it holds every field across the start cycle. The issue stage's ready line is driven independently of `uopValid`, either held high or following a fixed stall pattern, so the stall paths are exercised without any combinational loop back into the block.

// File: rtl/elp_pkg.sv
package elp_pkg;
  // Strobes from the loop control to the operand datapath
  typedef struct packed {
    logic load;  // capture a new instruction
    logic step;  // current element accepted, move past it
  } ctlStrobe_t;
endpackage

// File: rtl/elp_datapath.sv
module elp_datapath
  import elp_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int MAX_VL = 64,
  localparam int LANE_W = $clog2(MAX_VL),
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int PTR_W  = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [REG_W-1:0]  rtBase,
  input  logic [REG_W-1:0]  raBase,
  input  logic [REG_W-1:0]  rbBase,
  input  logic              rtIsVec,
  input  logic              raIsVec,
  input  logic              rbIsVec,
  input  logic [VL_W-1:0]   vecLen,
  input  logic              predEnable,
  input  logic [MAX_VL-1:0] predMask,
  output logic              anyLeft,
  output logic              laterLeft,
  output logic              idxBad,
  output logic              destVec,
  output logic [LANE_W-1:0] uopElem,
  output logic [REG_W-1:0]  uopRt,
  output logic [REG_W-1:0]  uopRa,
  output logic [REG_W-1:0]  uopRb
);

  logic [REG_W-1:0]  rtReg, raReg, rbReg;
  logic              raVec, rbVec;
  logic [MAX_VL-1:0] laneMask;
  logic [MAX_VL-1:0] maskNext;
  logic [MAX_VL-1:0] pending;
  logic [PTR_W-1:0]  elemPtr;
  logic [LANE_W-1:0] found;
  logic [REG_W:0]    sumRt, sumRa, sumRb;
  int                vlLimit;

  // Enabled lanes for the incoming instruction, clamped to MAX_VL
  always_comb begin
    vlLimit = (int'(vecLen) > MAX_VL) ? MAX_VL : int'(vecLen);
    for (int i = 0; i < MAX_VL; i++) begin
      maskNext[i] = (!predEnable || predMask[i]) && (i < vlLimit);
    end
  end

  // Lanes still to visit, lowest one first
  always_comb begin
    found     = '0;
    laterLeft = 1'b0;
    for (int i = 0; i < MAX_VL; i++) begin
      pending[i] = laneMask[i] && (i >= int'(elemPtr));
    end
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (pending[i]) found = LANE_W'(i);
    end
    for (int i = 0; i < MAX_VL; i++) begin
      if (pending[i] && (i > int'(found))) laterLeft = 1'b1;
    end
    anyLeft = |pending;
  end

  // Register index per operand, one spare bit to catch overflow
  always_comb begin
    sumRt = {1'b0, rtReg} + (destVec ? (REG_W+1)'(found) : '0);
    sumRa = {1'b0, raReg} + (raVec   ? (REG_W+1)'(found) : '0);
    sumRb = {1'b0, rbReg} + (rbVec   ? (REG_W+1)'(found) : '0);
    idxBad = sumRt[REG_W] | sumRa[REG_W] | sumRb[REG_W];
  end

  assign uopElem = found;
  assign uopRt   = sumRt[REG_W-1:0];
  assign uopRa   = sumRa[REG_W-1:0];
  assign uopRb   = sumRb[REG_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtReg    <= '0;
      raReg    <= '0;
      rbReg    <= '0;
      destVec  <= 1'b0;
      raVec    <= 1'b0;
      rbVec    <= 1'b0;
      laneMask <= '0;
      elemPtr  <= '0;
    end else if (strobe.load) begin
      rtReg    <= rtBase;
      raReg    <= raBase;
      rbReg    <= rbBase;
      destVec  <= rtIsVec;
      raVec    <= raIsVec;
      rbVec    <= rbIsVec;
      laneMask <= maskNext;
      elemPtr  <= '0;
    end else if (strobe.step) begin
      elemPtr  <= {1'b0, found} + PTR_W'(1);
    end
  end

  // R5
  step_has_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (anyLeft && !idxBad));

  // R5
  ptr_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (elemPtr > $past(elemPtr)));

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.load) |=> ($stable(uopElem) && $stable(uopRt) && $stable(uopRa) && $stable(uopRb)));

endmodule

// File: rtl/elp_ctrl.sv
module elp_ctrl
  import elp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instStart,
  input  logic       uopReady,
  input  logic       anyLeft,
  input  logic       laterLeft,
  input  logic       idxBad,
  input  logic       destVec,
  output logic       uopValid,
  output logic       pcHold,
  output logic       instDone,
  output logic       idxError,
  output ctlStrobe_t strobe
);

  typedef enum logic {LOOP_IDLE, LOOP_RUN} loopState_t;
  loopState_t state;
  logic isRun, finishNow, errNow;

  always_comb begin
    isRun       = (state == LOOP_RUN);
    uopValid    = isRun && anyLeft && !idxBad;
    strobe.load = !isRun && instStart;
    strobe.step = uopValid && uopReady;
    finishNow   = isRun && (!uopValid || (uopReady && (!destVec || !laterLeft)));
    errNow      = isRun && anyLeft && idxBad;
  end

  assign pcHold = isRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= LOOP_IDLE;
      instDone <= 1'b0;
      idxError <= 1'b0;
    end else begin
      instDone <= finishNow;
      idxError <= errNow;
      if (strobe.load)    state <= LOOP_RUN;
      else if (finishNow) state <= LOOP_IDLE;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    instDone |=> !instDone);

  // R2
  done_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    instDone |-> !pcHold);

  // R4
  scalar_dest_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopReady && !destVec) |=> !uopValid);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxError |-> instDone);

  // R11
  valid_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopReady) |=> uopValid);

endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import elp_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int MAX_VL = 64,
  localparam int LANE_W = $clog2(MAX_VL),
  localparam int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instStart,
  input  logic [REG_W-1:0]  rtBase,
  input  logic [REG_W-1:0]  raBase,
  input  logic [REG_W-1:0]  rbBase,
  input  logic              rtIsVec,
  input  logic              raIsVec,
  input  logic              rbIsVec,
  input  logic [VL_W-1:0]   vecLen,
  input  logic              predEnable,
  input  logic [MAX_VL-1:0] predMask,
  output logic              uopValid,
  input  logic              uopReady,
  output logic [LANE_W-1:0] uopElem,
  output logic [REG_W-1:0]  uopRt,
  output logic [REG_W-1:0]  uopRa,
  output logic [REG_W-1:0]  uopRb,
  output logic              pcHold,
  output logic              instDone,
  output logic              idxError
);

  ctlStrobe_t strobe;
  logic anyLeft, laterLeft, idxBad, destVec;

  elp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instStart (instStart),
    .uopReady  (uopReady),
    .anyLeft   (anyLeft),
    .laterLeft (laterLeft),
    .idxBad    (idxBad),
    .destVec   (destVec),
    .uopValid  (uopValid),
    .pcHold    (pcHold),
    .instDone  (instDone),
    .idxError  (idxError),
    .strobe    (strobe)
  );

  elp_datapath #(.REG_W(REG_W), .MAX_VL(MAX_VL)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rtBase     (rtBase),
    .raBase     (raBase),
    .rbBase     (rbBase),
    .rtIsVec    (rtIsVec),
    .raIsVec    (raIsVec),
    .rbIsVec    (rbIsVec),
    .vecLen     (vecLen),
    .predEnable (predEnable),
    .predMask   (predMask),
    .anyLeft    (anyLeft),
    .laterLeft  (laterLeft),
    .idxBad     (idxBad),
    .destVec    (destVec),
    .uopElem    (uopElem),
    .uopRt      (uopRt),
    .uopRa      (uopRa),
    .uopRb      (uopRb)
  );

  // R5
  elem_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopReady) |=> (!uopValid || (uopElem > $past(uopElem))));

endmodule

// File: tb/elem_loop_seq_bench.sv
module elem_loop_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instStart = 1'b0;
  logic [6:0]  rtBase = '0, raBase = '0, rbBase = '0;
  logic        rtIsVec = 1'b0, raIsVec = 1'b0, rbIsVec = 1'b0;
  logic [6:0]  vecLen = '0;
  logic        predEnable = 1'b0;
  logic [63:0] predMask = '0;
  logic        uopValid;
  logic        uopReady = 1'b0;
  logic [5:0]  uopElem;
  logic [6:0]  uopRt, uopRa, uopRb;
  logic        pcHold, instDone, idxError;

  typedef struct packed {
    logic [5:0] elem;
    logic [6:0] rt;
    logic [6:0] ra;
    logic [6:0] rb;
  } uopItem_t;

  uopItem_t expQ[$];
  string    curTag = "R1";
  int       stallMode = 0;
  int       readyCnt = 0;
  int       compared = 0;
  int       mismatched = 0;
  int       cycles = 0;
  bit       finished = 1'b0;

  always #4 clk = ~clk;

  elem_loop_seq u_elem_loop_seq (
    .clk(clk), .rstN(rstN), .instStart(instStart),
    .rtBase(rtBase), .raBase(raBase), .rbBase(rbBase),
    .rtIsVec(rtIsVec), .raIsVec(raIsVec), .rbIsVec(rbIsVec),
    .vecLen(vecLen), .predEnable(predEnable), .predMask(predMask),
    .uopValid(uopValid), .uopReady(uopReady), .uopElem(uopElem),
    .uopRt(uopRt), .uopRa(uopRa), .uopRb(uopRb),
    .pcHold(pcHold), .instDone(instDone), .idxError(idxError)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: drive ready, then pop and compare each handshake
  always @(negedge clk) begin
    readyCnt++;
    if (stallMode == 0) uopReady <= 1'b1;
    else                uopReady <= ((readyCnt % 3) != 1) && ((readyCnt % 7) != 2);
    #1;
    if (rstN && uopValid && uopReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, curTag, "unexpected uop", {uopElem, uopRt, uopRa, uopRb}, 0);
      end else begin
        uopItem_t e;
        e = expQ.pop_front();
        check({uopElem, uopRt, uopRa, uopRb} == e, curTag, "uop elem/rt/ra/rb",
              {uopElem, uopRt, uopRa, uopRb}, e);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, curTag, "watchdog expired", cycles, 100000);
      finish_run();
    end
  end

  // Driver: build expected items from the requirements, then start
  task automatic run_inst(input string tag, input int rt, input int ra, input int rb,
                          input bit rtv, input bit rav, input bit rbv, input int vl,
                          input bit pe, input logic [63:0] pm, input int stall);
    int  lim;
    bit  expErr;
    int  waitCnt;
    lim = (vl > 64) ? 64 : vl;
    expErr = 1'b0;
    curTag = tag;
    stallMode = stall;
    for (int i = 0; i < lim; i++) begin
      int r0, r1, r2;
      uopItem_t it;
      if (pe && !pm[i]) continue;
      r0 = rt + (rtv ? i : 0);
      r1 = ra + (rav ? i : 0);
      r2 = rb + (rbv ? i : 0);
      if (r0 > 127 || r1 > 127 || r2 > 127) begin
        expErr = 1'b1;
        break;
      end
      it.elem = 6'(i); it.rt = 7'(r0); it.ra = 7'(r1); it.rb = 7'(r2);
      expQ.push_back(it);
      if (!rtv) break;
    end
    @(negedge clk);
    rtBase = 7'(rt); raBase = 7'(ra); rbBase = 7'(rb);
    rtIsVec = rtv; raIsVec = rav; rbIsVec = rbv;
    vecLen = 7'(vl); predEnable = pe; predMask = pm;
    instStart = 1'b1;
    @(negedge clk);
    instStart = 1'b0;
    #2;
    check(pcHold == 1'b1, "R2", "pcHold after start", pcHold, 1);
    waitCnt = 0;
    while (!instDone && waitCnt < 1000) begin
      @(negedge clk);
      #2;
      waitCnt++;
    end
    check(instDone == 1'b1, "R2", "instDone seen", instDone, 1);
    check(pcHold == 1'b0, "R2", "pcHold low at done", pcHold, 0);
    check(idxError == expErr, (expErr ? "R10" : tag), "idxError at done", idxError, expErr);
    check(expQ.size() == 0, tag, "uops left unissued", expQ.size(), 0);
    expQ.delete();
    @(negedge clk);
    #2;
    check(instDone == 1'b0, "R2", "instDone one cycle", instDone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    check({uopValid, pcHold, instDone, idxError} == 4'b0, "R1", "outputs in reset",
          {uopValid, pcHold, instDone, idxError}, 0);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check({uopValid, pcHold, instDone, idxError} == 4'b0, "R1", "outputs after reset",
          {uopValid, pcHold, instDone, idxError}, 0);

    // R3, R7: all vector, plain fill
    run_inst("R7", 10, 20, 30, 1, 1, 1, 5, 0, 64'h0, 0);
    // R3: mixed flags, scalar first source, with stalls (R11)
    run_inst("R3", 40, 5, 60, 1, 0, 1, 8, 0, 64'h0, 1);
    // R11: all vector under stalls
    run_inst("R11", 0, 1, 2, 1, 1, 1, 12, 0, 64'h0, 1);
    // R4: scalar destination stops after one
    run_inst("R4", 7, 8, 9, 0, 1, 1, 8, 0, 64'h0, 0);
    // R6: masked elements skipped, mixed operands, stalls
    run_inst("R6", 50, 3, 70, 1, 0, 1, 8, 1, 64'hB6, 1);
    // R6: mask ignored when predEnable is 0
    run_inst("R6", 2, 4, 6, 1, 1, 0, 6, 0, 64'h0, 0);
    // R8: scalar destination, first enabled element is 3
    run_inst("R8", 11, 12, 13, 0, 1, 1, 8, 1, 64'h08, 0);
    // R8: nothing enabled
    run_inst("R8", 11, 12, 13, 0, 1, 1, 4, 1, 64'h0, 0);
    // R9: zero length
    run_inst("R9", 1, 2, 3, 1, 1, 1, 0, 0, 64'h0, 0);
    // R10: destination overflows at element 3
    run_inst("R10", 125, 0, 0, 1, 1, 0, 6, 0, 64'h0, 1);
    // R10: first element beyond reach after masking
    run_inst("R10", 0, 120, 0, 1, 1, 1, 16, 1, 64'hFF00, 0);
    // R7: full length, source ends exactly at 127
    run_inst("R7", 0, 64, 5, 1, 1, 0, 64, 0, 64'h0, 0);
    // R7: length above 64 clamps, alternating mask (R5)
    run_inst("R5", 10, 0, 60, 1, 1, 0, 100, 1, 64'h5555_5555_5555_5555, 1);
    // R7: single element
    run_inst("R7", 127, 127, 127, 1, 1, 1, 1, 0, 64'h0, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule